// File: doc/BRIEF.md
# Serial Flash Deep Power-Down Command Front End

This block sits at the serial port of a flash device and acts as an SPI mode-0 slave. It collects opcode bytes from the data input while chip select is low. It keeps track of the device power state, which is one of standby, entering power-down, powered down or waking. Two opcodes change that state: a sleep opcode (0xB9) and a wake opcode (0xAB). Either one acts only when chip select rises after a frame of exactly eight bits. Each transition runs a programmable delay counted in clock cycles. While the device is powered down, every opcode except wake is dropped.

A status-read opcode (0xD7) returns one status byte, repeated for as long as the master keeps clocking. Any other complete opcode received in idle standby produces a one-cycle pulse that carries the opcode to a downstream command engine. The serial pins are synchronised into the system clock domain, so each half period of SCK must last several clock cycles.

Top module: `flash_pwr_ctl`

## Requirements
- R1: After reset, pwr_state is 0 (standby), busy is 0, so is 0 and cmd_valid is 0. State codes are 0 standby, 1 entering, 2 powered down, 3 waking.
- R2: A frame of exactly eight bits carrying 0xB9 (MSB first, sampled on SCK rising edges) moves standby to entering, and then to powered down. Nothing changes while chip select stays low after the eighth bit; the change starts only when chip select rises.
- R3: A frame whose bit count is not eight (for example 7 or 9) is discarded, and the power state does not change.
- R4: Entering lasts exactly ENTER_CYC clock cycles with busy high, and then the state becomes powered down.
- R5: While powered down, every opcode other than 0xAB is ignored: no cmd_valid pulse occurs, so stays 0 during a status read, and 0xB9 leaves the state unchanged.
- R6: An eight-bit 0xAB frame while powered down starts waking, which lasts exactly RESUME_CYC cycles with busy high and then returns to standby. 0xAB received in standby has no effect.
- R7: While entering or waking, no frame changes the state and no cmd_valid pulse is produced.
- R8: After the eight bits of opcode 0xD7, in any state except powered down, so presents the status byte MSB first. The first bit is driven after the SCK falling edge that follows the opcode, and each later bit after a later falling edge. The byte repeats every eight bits. Status layout, bit 7 down to bit 0: ready, cmp_flag, density code 0101, prot_flag, page_flag.
- R9: The ready bit of the status byte is 0 while an entry or wake delay runs, and 1 in standby.
- R10: Any other opcode completed in idle standby produces cmd_valid high for one cycle, with cmd_op equal to that opcode. The pulse is raised after the eighth SCK rising edge, without waiting for chip select to rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data in |
| cmp_flag | input | 1 | Compare result reported in status bit 6 |
| prot_flag | input | 1 | Protection flag reported in status bit 1 |
| page_flag | input | 1 | Page-size flag reported in status bit 0 |
| so | output | 1 | Serial data out (status byte) |
| busy | output | 1 | High while an entry or wake delay runs |
| pwr_state | output | 2 | Power state code |
| cmd_valid | output | 1 | One-cycle pulse for a forwarded opcode |
| cmd_op | output | 8 | Forwarded opcode |

## Verification
The checker watches the following on every cycle:
- only the legal state moves occur;
- each entry and wake delay lasts exactly its parameter, measured by counters in the checker;
- so stays low while powered down;
- cmd_valid is a single-cycle pulse that appears only in standby and never carries a power or status opcode.

Some behaviours can only be shown by the bench's scenarios, because they depend on what was shifted in:
- that the correct frame length gates each command;
- that a change waits for chip select to rise;
- the status bit values and their repetition, and the cleared ready bit during a delay;
- that frames arriving during a delay or during power-down are dropped.

// File: rtl/flash_pwr_pkg.sv
package flash_pwr_pkg;
  localparam int OPW = 8;

  typedef enum logic [1:0] {
    PS_STBY  = 2'd0,
    PS_ENTER = 2'd1,
    PS_DOWN  = 2'd2,
    PS_WAKE  = 2'd3
  } pwr_state_t;

  localparam logic [OPW-1:0] OP_SLEEP = 8'hB9;
  localparam logic [OPW-1:0] OP_WAKE  = 8'hAB;
  localparam logic [OPW-1:0] OP_STAT  = 8'hD7;
  localparam logic [3:0]     DENSITY  = 4'b0101;
endpackage

// File: rtl/fpd_sync.sv
module fpd_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fpd_rx.sv
module fpd_rx
  import flash_pwr_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n_s,
  input  logic           sck_s,
  input  logic           si_s,
  output logic           sck_fall,
  output logic           cs_rise,
  output logic           byte_done,
  output logic           frame_ok,
  output logic [OPW-1:0] opcode
);
  localparam int CW = $clog2(OPW + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(OPW);
  localparam logic [CW-1:0] CNT_LAST = CW'(OPW - 1);
  localparam logic [CW-1:0] CNT_SAT  = CW'(OPW + 1);

  logic           sck_q, cs_q;
  logic [CW-1:0]  bit_cnt, cnt_d;
  logic [OPW-1:0] shreg, sh_d;
  logic           done_q, done_d;
  logic           sck_rise;

  assign sck_rise = sck_s & ~sck_q & ~cs_n_s;
  assign sck_fall = ~sck_s & sck_q & ~cs_n_s;
  assign cs_rise  = cs_n_s & ~cs_q;

  always_comb begin
    cnt_d  = bit_cnt;
    sh_d   = shreg;
    done_d = 1'b0;
    if (cs_n_s) begin
      cnt_d = '0;
    end else if (sck_rise) begin
      sh_d   = {shreg[OPW-2:0], si_s};
      done_d = (bit_cnt == CNT_LAST);
      if (bit_cnt != CNT_SAT) cnt_d = bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      bit_cnt <= '0;
      shreg   <= '0;
      done_q  <= 1'b0;
    end else begin
      sck_q   <= sck_s;
      cs_q    <= cs_n_s;
      bit_cnt <= cnt_d;
      shreg   <= sh_d;
      done_q  <= done_d;
    end
  end

  assign byte_done = done_q;
  assign frame_ok  = (bit_cnt == CNT_FULL);
  assign opcode    = shreg;
endmodule

// File: rtl/fpd_fsm.sv
module fpd_fsm
  import flash_pwr_pkg::*;
#(
  parameter int ENTER_CYC  = 400,
  parameter int RESUME_CYC = 300
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_rise,
  input  logic           frame_ok,
  input  logic [OPW-1:0] opcode,
  output pwr_state_t     state,
  output logic           busy
);
  localparam int MAXC = (ENTER_CYC > RESUME_CYC) ? ENTER_CYC : RESUME_CYC;
  localparam int TW   = $clog2(MAXC + 1);
  localparam logic [TW-1:0] T_ENTER = TW'(ENTER_CYC - 1);
  localparam logic [TW-1:0] T_WAKE  = TW'(RESUME_CYC - 1);

  pwr_state_t st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic cmd_end;

  assign cmd_end = cs_rise & frame_ok;

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    unique case (st_q)
      PS_STBY: begin
        if (cmd_end && opcode == OP_SLEEP) begin
          st_d  = PS_ENTER;
          tmr_d = T_ENTER;
        end
      end
      PS_ENTER: begin
        if (tmr_q == '0) st_d = PS_DOWN;
        else             tmr_d = tmr_q - 1'b1;
      end
      PS_DOWN: begin
        if (cmd_end && opcode == OP_WAKE) begin
          st_d  = PS_WAKE;
          tmr_d = T_WAKE;
        end
      end
      PS_WAKE: begin
        if (tmr_q == '0) st_d = PS_STBY;
        else             tmr_d = tmr_q - 1'b1;
      end
      default: st_d = PS_STBY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_STBY;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
    end
  end

  assign state = st_q;
  assign busy  = (st_q == PS_ENTER) || (st_q == PS_WAKE);
endmodule

// File: rtl/fpd_stat.sv
module fpd_stat
  import flash_pwr_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cs_n_s,
  input  logic           sck_fall,
  input  logic           byte_done,
  input  logic [OPW-1:0] opcode,
  input  pwr_state_t     state,
  input  logic [7:0]     stat_byte,
  output logic           so
);
  logic       armed_q, armed_d;
  logic       act_q, act_d;
  logic [7:0] sh_q, sh_d;
  logic [2:0] obit_q, obit_d;
  logic       reload;

  assign reload = sck_fall & (armed_q | (act_q & (obit_q == 3'd7)));

  always_comb begin
    armed_d = armed_q;
    act_d   = act_q;
    sh_d    = sh_q;
    obit_d  = obit_q;
    if (cs_n_s || state == PS_DOWN) begin
      armed_d = 1'b0;
      act_d   = 1'b0;
      obit_d  = '0;
    end else begin
      if (byte_done && opcode == OP_STAT) armed_d = 1'b1;
      if (reload) begin
        sh_d    = stat_byte;
        obit_d  = '0;
        armed_d = 1'b0;
        act_d   = 1'b1;
      end else if (sck_fall && act_q) begin
        sh_d   = {sh_q[6:0], 1'b0};
        obit_d = obit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      act_q   <= 1'b0;
      sh_q    <= '0;
      obit_q  <= '0;
    end else begin
      armed_q <= armed_d;
      act_q   <= act_d;
      sh_q    <= sh_d;
      obit_q  <= obit_d;
    end
  end

  assign so = act_q & sh_q[7];
endmodule

// File: rtl/flash_pwr_ctl.sv
module flash_pwr_ctl
  import flash_pwr_pkg::*;
#(
  parameter int ENTER_CYC   = 400,
  parameter int RESUME_CYC  = 300,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       si,
  input  logic       cmp_flag,
  input  logic       prot_flag,
  input  logic       page_flag,
  output logic       so,
  output logic       busy,
  output logic [1:0] pwr_state,
  output logic       cmd_valid,
  output logic [7:0] cmd_op
);
  logic           rst_ns;
  logic [2:0]     pins_s;
  logic           sck_fall, cs_rise, byte_done, frame_ok;
  logic [OPW-1:0] opcode;
  pwr_state_t     state;
  logic [7:0]     stat_byte;
  logic           cv_q, cv_d;
  logic [OPW-1:0] cop_q, cop_d;
  logic           fwd_op;

  fpd_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_ns)
  );

  fpd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_pin_sync (
    .clk(clk), .rst_n(rst_ns), .d({cs_n, sck, si}), .q(pins_s)
  );

  fpd_rx u_rx (
    .clk(clk), .rst_n(rst_ns),
    .cs_n_s(pins_s[2]), .sck_s(pins_s[1]), .si_s(pins_s[0]),
    .sck_fall(sck_fall), .cs_rise(cs_rise), .byte_done(byte_done),
    .frame_ok(frame_ok), .opcode(opcode)
  );

  fpd_fsm #(.ENTER_CYC(ENTER_CYC), .RESUME_CYC(RESUME_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_ns), .cs_rise(cs_rise), .frame_ok(frame_ok),
    .opcode(opcode), .state(state), .busy(busy)
  );

  assign stat_byte = {~busy, cmp_flag, DENSITY, prot_flag, page_flag};

  fpd_stat u_stat (
    .clk(clk), .rst_n(rst_ns), .cs_n_s(pins_s[2]), .sck_fall(sck_fall),
    .byte_done(byte_done), .opcode(opcode), .state(state),
    .stat_byte(stat_byte), .so(so)
  );

  assign fwd_op = (opcode != OP_SLEEP) && (opcode != OP_WAKE) && (opcode != OP_STAT);

  always_comb begin
    cv_d  = byte_done & (state == PS_STBY) & fwd_op;
    cop_d = cop_q;
    if (cv_d) cop_d = opcode;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      cv_q  <= 1'b0;
      cop_q <= '0;
    end else begin
      cv_q  <= cv_d;
      cop_q <= cop_d;
    end
  end

  assign cmd_valid = cv_q;
  assign cmd_op    = cop_q;
  assign pwr_state = state;
endmodule

// File: rtl/flash_pwr_chk.sv
module flash_pwr_chk #(
  parameter int ENTER_CYC  = 400,
  parameter int RESUME_CYC = 300
) (
  input logic       clk,
  input logic       rst_n,
  input logic       so,
  input logic       busy,
  input logic [1:0] pwr_state,
  input logic       cmd_valid,
  input logic [7:0] cmd_op
);
  localparam int EW = $clog2(ENTER_CYC + 1) + 1;
  localparam int WW = $clog2(RESUME_CYC + 1) + 1;

  logic [EW-1:0] enter_run;
  logic [WW-1:0] wake_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enter_run <= '0;
      wake_run  <= '0;
    end else begin
      enter_run <= (pwr_state == 2'd1) ? enter_run + 1'b1 : '0;
      wake_run  <= (pwr_state == 2'd3) ? wake_run + 1'b1 : '0;
    end
  end

  p_stby_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd0) |=> (pwr_state == 2'd0 || pwr_state == 2'd1));

  p_enter_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd1) |=> (pwr_state == 2'd1 || pwr_state == 2'd2));

  p_enter_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd2 && enter_run != '0) |-> (enter_run == EW'(ENTER_CYC)));

  p_down_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd2) |=> (pwr_state == 2'd2 || pwr_state == 2'd3));

  p_down_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd2) |=> !so);

  p_wake_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd3) |=> (pwr_state == 2'd3 || pwr_state == 2'd0));

  p_wake_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd0 && wake_run != '0) |-> (wake_run == WW'(RESUME_CYC)));

  p_busy_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pwr_state == 2'd1 || pwr_state == 2'd3));

  p_cmd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  p_cmd_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (pwr_state == 2'd0 && cmd_op != 8'hB9 && cmd_op != 8'hAB && cmd_op != 8'hD7));
endmodule

bind flash_pwr_ctl flash_pwr_chk #(.ENTER_CYC(ENTER_CYC), .RESUME_CYC(RESUME_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .so(so), .busy(busy), .pwr_state(pwr_state),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op)
);

// File: tb/tb_flash_pwr_ctl.sv
module tb_flash_pwr_ctl;
  localparam int ENTER_CYC  = 400;
  localparam int RESUME_CYC = 300;
  localparam int HALF       = 6;
  localparam int K_CMD      = 1;
  localparam int K_STAT     = 2;

  typedef struct {
    int          kind;
    string       req;
    logic [15:0] val;
  } item_t;

  logic clk = 1'b0;
  logic rst_n, cs_n, sck, si, cmp_flag, prot_flag, page_flag;
  logic so, busy, cmd_valid;
  logic [1:0] pwr_state;
  logic [7:0] cmd_op;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  item_t exp_q[$];
  item_t act_q[$];

  always #5 clk = ~clk;

  flash_pwr_ctl #(.ENTER_CYC(ENTER_CYC), .RESUME_CYC(RESUME_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .cmp_flag(cmp_flag), .prot_flag(prot_flag), .page_flag(page_flag),
    .so(so), .busy(busy), .pwr_state(pwr_state),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: capture forwarded opcodes and compare against the scoreboard
  always @(negedge clk) begin
    if (rst_n && cmd_valid) act_q.push_back('{K_CMD, "", {8'h00, cmd_op}});
    while (act_q.size() > 0) begin
      item_t a;
      a = act_q.pop_front();
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R7/R10 unexpected item: actual=%h expected=none", a.val);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        if (a.kind != e.kind || a.val !== e.val) begin
          n_bad++;
          $display("FAIL %s: actual=%h expected=%h", e.req, a.val, e.val);
        end
      end
    end
  end

  task automatic xfer(input logic [23:0] dat, input int nbits, input bit hold,
                      output logic [15:0] rx);
    rx = '0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      si = dat[23-i];
      repeat (HALF) @(negedge clk);
      if (i >= 8) rx = {rx[14:0], so};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    if (!hold) cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic op(input logic [7:0] code, input int nbits);
    logic [15:0] rx;
    xfer({code, 16'h0000}, nbits, 1'b0, rx);
    repeat (10) @(negedge clk);
  endtask

  task automatic read_stat(input int nbytes, output logic [15:0] rx);
    xfer({8'hD7, 16'h0000}, 8 + 8 * nbytes, 1'b0, rx);
  endtask

  task automatic push_exp(input int kind, input string req, input logic [15:0] v);
    exp_q.push_back('{kind, req, v});
  endtask

  // raise chip select of a held frame and count busy cycles
  task automatic release_count(output int n);
    int guard;
    @(negedge clk);
    cs_n = 1'b1;
    guard = 0;
    n = 0;
    while (!busy && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    while (busy && n < 5000) begin
      n++;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [15:0] rx;
    int n;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0;
    cmp_flag = 1'b1; prot_flag = 1'b0; page_flag = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 state", {14'h0, pwr_state}, 16'd0);
    chk("R1 busy", {15'h0, busy}, 16'd0);
    chk("R1 so", {15'h0, so}, 16'd0);
    chk("R1 cmd_valid", {15'h0, cmd_valid}, 16'd0);

    // R8 status read, two bytes, two flag patterns; R9 ready set in standby
    read_stat(2, rx);
    push_exp(K_STAT, "R8/R9 status 0xD5 repeated", 16'hD5D5);
    act_q.push_back('{K_STAT, "", rx});
    cmp_flag = 1'b0; prot_flag = 1'b1; page_flag = 1'b0;
    read_stat(1, rx);
    push_exp(K_STAT, "R8 status 0x96", 16'h0096);
    act_q.push_back('{K_STAT, "", rx});
    repeat (4) @(negedge clk);

    // R10 forwarded opcodes
    push_exp(K_CMD, "R10 forward 0x52", 16'h0052);
    op(8'h52, 8);
    push_exp(K_CMD, "R10 forward 0x0B", 16'h000B);
    op(8'h0B, 8);

    // R6 wake in standby has no effect
    op(8'hAB, 8);
    chk("R6 wake in standby", {14'h0, pwr_state}, 16'd0);

    // R3 wrong frame lengths
    op(8'hB9, 7);
    chk("R3 seven-bit sleep", {14'h0, pwr_state}, 16'd0);
    op(8'hB9, 9);
    chk("R3 nine-bit sleep", {14'h0, pwr_state}, 16'd0);

    // R2 held chip select: no change before it rises
    xfer({8'hB9, 16'h0}, 8, 1'b1, rx);
    repeat (20) @(negedge clk);
    chk("R2 held cs no change", {14'h0, pwr_state}, 16'd0);
    release_count(n);
    chk("R4 enter length", n[15:0], 16'(ENTER_CYC));
    chk("R2 powered down", {14'h0, pwr_state}, 16'd2);

    // R5 filtering while powered down
    op(8'h52, 8);
    read_stat(1, rx);
    chk("R5 status silent", rx, 16'h0000);
    op(8'hB9, 8);
    chk("R5 sleep ignored", {14'h0, pwr_state}, 16'd2);
    op(8'hAB, 9);
    chk("R3 nine-bit wake", {14'h0, pwr_state}, 16'd2);

    // R6 wake and its length
    xfer({8'hAB, 16'h0}, 8, 1'b1, rx);
    release_count(n);
    chk("R6 wake length", n[15:0], 16'(RESUME_CYC));
    chk("R6 back to standby", {14'h0, pwr_state}, 16'd0);

    // R9 ready clear during entry; R7 wake ignored during entry
    op(8'hB9, 8);
    chk("R2 entering", {14'h0, pwr_state}, 16'd1);
    read_stat(1, rx);
    push_exp(K_STAT, "R9 ready clear while entering", 16'h0016);
    act_q.push_back('{K_STAT, "", rx});
    op(8'hAB, 8);
    chk("R7 still entering", {14'h0, pwr_state}, 16'd1);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R7 wake during entry ignored", {14'h0, pwr_state}, 16'd2);

    // R7 frames during wake are ignored
    op(8'hAB, 8);
    op(8'hB9, 8);
    op(8'h52, 8);
    chk("R7 still waking", {14'h0, pwr_state}, 16'd3);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R7 standby after wake", {14'h0, pwr_state}, 16'd0);

    push_exp(K_CMD, "R10 forward after wake", 16'h0020);
    op(8'h20, 8);
    repeat (10) @(negedge clk);
    chk("R10 scoreboard drained", 16'(exp_q.size()), 16'd0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule